// File: doc/BRIEF.md
# Four-Channel Current DAC Control Register Target

This block is a two-wire serial bus target (I2C-compatible) that holds the four 8-bit control words of a four-channel current DAC in which each channel can either sink or source current. SCL and SDA are sampled by a faster system clock. The block recognises bus conditions, answers at one of four addresses chosen by two strap inputs, and accepts a register pointer followed by data bytes. It can also return the pointed-to register on a read.

Each control word holds a direction bit in bit 7 and a 7-bit magnitude in bits 6:0. The block drives the raw words plus a decoded magnitude, a "source" flag and an "on" flag for each channel. A zero magnitude forces the channel off whatever the direction bit says. The analog stage that turns these words into currents sits outside this block.

Top module: `dac_ctrl_i2c`

## Requirements
- R1: The block answers only to the 7-bit address {1,0,0,1,0,addrStrap[1],addrStrap[0]}. The address byte is that address in bits 7:1 and the read/write flag in bit 0, where 1 means read. The block pulls SDA low on the ninth clock of a matching address byte.
- R2: Pointer values 0xF8, 0xF9, 0xFA and 0xFB select channels 0, 1, 2 and 3. Channel n occupies chanRegs[8n+7:8n].
- R3: Bit 7 of a control word is the direction (1 = source, 0 = sink) and bits 6:0 are the magnitude. chanMag[7n+6:7n] carries the magnitude of channel n, and chanSource[n] is high for a sourcing channel that is on.
- R4: A magnitude of zero makes chanOn[n] low and chanSource[n] low, whatever the direction bit is.
- R5: After reset every control word is 0x00, every chanOn bit is low and SDA is released.
- R6: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START restarts address reception exactly as a START does, whatever the block was doing.
- R7: In a write, the first byte after the address is the pointer and each later byte is data. Bytes arrive MSB first and are sampled on SCL rising. The block ACKs every byte by pulling SDA low on the ninth clock.
- R8: In a read, the block shifts out the pointed-to register MSB first, changing SDA only while SCL is low. It keeps sending the same register after each master ACK and releases SDA after a master NACK.
- R9: After an address byte that does not match, the block never pulls SDA low and changes no register until the next START.
- R10: The pointer never advances. Further data bytes in one write overwrite the same register, and further bytes of a read repeat it.
- R11: A pointer outside 0xF8–0xFB is ACKed. Data written through it is discarded, and a read through it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock as seen at the pin |
| sdaIn | input | 1 | Bus data as seen at the pin |
| addrStrap | input | 2 | Strap inputs forming the low two address bits |
| sdaDriveLow | output | 1 | High to pull SDA low (open-drain enable) |
| chanRegs | output | 32 | Raw control words, channel n in bits 8n+7:8n |
| chanMag | output | 28 | Decoded magnitudes, channel n in bits 7n+6:7n |
| chanSource | output | 4 | Per channel: on and sourcing |
| chanOn | output | 4 | Per channel: non-zero magnitude |

## Verification
On every cycle the assertions check four things. The control words are zero straight after reset. A word changes only in the cycle after a write strobe from the bus controller. At most one channel changes at a time, and the SDA drive changes only while SCL is low. Only the bench scenarios can show the rest. These cover address matching for different strap values, the pointer-then-data order, and overwrite without auto-increment. They also cover discarded out-of-range writes, zero reads, silence after a foreign address until a repeated START, and the sign/magnitude decode with the zero-magnitude override.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              ptrLoad;
    logic              regWrite;
    logic [BYTE_W-1:0] rxByte;
  } busStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD, ST_RD_ACK, ST_IGNORE
  } busState_t;
endpackage

// File: rtl/dac_i2c_ctrl.sv
module dac_i2c_ctrl
  import dac_i2c_pkg::*;
#(
  parameter int         STRAP_W   = 2,
  parameter logic [6:0] ADDR_BASE = 7'b1001000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [STRAP_W-1:0]  strap,
  input  logic [BYTE_W-1:0]   rdByte,
  output busStrobe_t          strb,
  output logic                sdaDriveLow
);
  localparam int SYNC_D = 3;

  logic [SYNC_D-1:0] sclPipe, sdaPipe;
  logic sclNow, sclPrev, sdaNow, sdaPrev;
  logic sclRise, sclFall, startEv, stopEv;
  busState_t state;
  logic [3:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic readMode, masterAck;
  logic addrHit;

  // two-flop synchronizer plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_D-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_D-2:0], sdaIn};
    end
  end

  assign sclNow  = sclPipe[1];
  assign sclPrev = sclPipe[2];
  assign sdaNow  = sdaPipe[1];
  assign sdaPrev = sdaPipe[2];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  assign addrHit = (shiftReg[7:1] == {ADDR_BASE[6:STRAP_W], strap});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
      strb      <= '0;
    end else begin
      strb.ptrLoad  <= 1'b0;
      strb.regWrite <= 1'b0;
      if (startEv) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
      end else if (stopEv) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_DATA: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (addrHit) begin
                  readMode <= shiftReg[0];
                  state    <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_PTR) begin
                strb.ptrLoad <= 1'b1;
                strb.rxByte  <= shiftReg;
                state        <= ST_PTR_ACK;
              end else begin
                strb.regWrite <= 1'b1;
                strb.rxByte   <= shiftReg;
                state         <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              if (readMode) begin
                shiftReg <= rdByte;
                state    <= ST_RD;
              end else begin
                state <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_DATA_ACK: begin
            if (sclFall) state <= ST_DATA;
          end
          ST_RD: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                bitCnt <= '0;
                state  <= ST_RD_ACK;
              end else begin
                shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
                bitCnt   <= bitCnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise) masterAck <= ~sdaNow;
            if (sclFall) begin
              if (masterAck) begin
                shiftReg <= rdByte;
                state    <= ST_RD;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = (state == ST_ADDR_ACK) || (state == ST_PTR_ACK) ||
                       (state == ST_DATA_ACK) ||
                       ((state == ST_RD) && !shiftReg[BYTE_W-1]);
endmodule

// File: rtl/dac_i2c_regs.sv
module dac_i2c_regs
  import dac_i2c_pkg::*;
#(
  parameter int         NUM_CH   = 4,
  parameter logic [7:0] PTR_BASE = 8'hF8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobe_t               strb,
  output logic [BYTE_W-1:0]        rdByte,
  output logic [NUM_CH*BYTE_W-1:0] chanRegs,
  output logic [NUM_CH*(BYTE_W-1)-1:0] chanMag,
  output logic [NUM_CH-1:0]        chanSource,
  output logic [NUM_CH-1:0]        chanOn
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int MAG_W = BYTE_W - 1;

  logic [BYTE_W-1:0] ptrReg;
  logic [BYTE_W-1:0] regFile [NUM_CH];
  logic ptrHit;
  logic [IDX_W-1:0] ptrIdx;

  assign ptrHit = (ptrReg[BYTE_W-1:IDX_W] == PTR_BASE[BYTE_W-1:IDX_W]);
  assign ptrIdx = ptrReg[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg <= '0;
      for (int i = 0; i < NUM_CH; i++) regFile[i] <= '0;
    end else begin
      if (strb.ptrLoad) ptrReg <= strb.rxByte;
      if (strb.regWrite && ptrHit) begin
        for (int i = 0; i < NUM_CH; i++)
          if (ptrIdx == IDX_W'(i)) regFile[i] <= strb.rxByte;
      end
    end
  end

  always_comb begin
    rdByte = '0;
    if (ptrHit) begin
      for (int i = 0; i < NUM_CH; i++)
        if (ptrIdx == IDX_W'(i)) rdByte = regFile[i];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chanRegs[g*BYTE_W +: BYTE_W] = regFile[g];
    assign chanMag[g*MAG_W +: MAG_W]    = regFile[g][MAG_W-1:0];
    assign chanOn[g]     = |regFile[g][MAG_W-1:0];
    assign chanSource[g] = chanOn[g] & regFile[g][BYTE_W-1];
  end
endmodule

// File: rtl/dac_ctrl_i2c.sv
module dac_ctrl_i2c
  import dac_i2c_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  logic [1:0]              addrStrap,
  output logic                    sdaDriveLow,
  output logic [NUM_CH*8-1:0]     chanRegs,
  output logic [NUM_CH*7-1:0]     chanMag,
  output logic [NUM_CH-1:0]       chanSource,
  output logic [NUM_CH-1:0]       chanOn
);
  busStrobe_t        strb;
  logic [BYTE_W-1:0] rdByte;

  dac_i2c_ctrl #(.STRAP_W(2), .ADDR_BASE(7'b1001000)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strap(addrStrap), .rdByte(rdByte), .strb(strb),
    .sdaDriveLow(sdaDriveLow)
  );

  dac_i2c_regs #(.NUM_CH(NUM_CH), .PTR_BASE(8'hF8)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .rdByte(rdByte),
    .chanRegs(chanRegs), .chanMag(chanMag),
    .chanSource(chanSource), .chanOn(chanOn)
  );
endmodule

// File: rtl/dac_i2c_chk.sv
module dac_i2c_chk #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                sclIn,
  input logic                sdaDriveLow,
  input logic [NUM_CH*8-1:0] chanRegs,
  input logic                regWrite
);
  logic afterRst;
  logic [NUM_CH*8-1:0] prevRegs;
  logic [NUM_CH-1:0] chg;

  always_ff @(posedge clk) afterRst <= !rstN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevRegs <= '0;
    else       prevRegs <= chanRegs;
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      chg[i] = (chanRegs[i*8 +: 8] != prevRegs[i*8 +: 8]);
  end

  p_reset_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    afterRst |-> (chanRegs == '0));

  p_change_needs_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanRegs) |-> $past(regWrite));

  p_write_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> !regWrite);

  p_one_channel_per_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chg));

  p_drive_while_scl_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);
endmodule

bind dac_ctrl_i2c dac_i2c_chk #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .chanRegs(chanRegs), .regWrite(strb.regWrite)
);

// File: tb/tb_dac_ctrl_i2c.sv
module tb_dac_ctrl_i2c;
  localparam int CLK_PERIOD = 10;
  localparam int QP = 6;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sdaDriveLow;
  logic [NCH*8-1:0] chanRegs;
  logic [NCH*7-1:0] chanMag;
  logic [NCH-1:0] chanSource, chanOn;
  logic sdaLine;

  int nTests = 0;
  int nFail = 0;
  logic [7:0] model [NCH];
  logic [7:0] ptrModel;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & ~sdaDriveLow;

  dac_ctrl_i2c #(.NUM_CH(NCH)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .addrStrap(strap), .sdaDriveLow(sdaDriveLow), .chanRegs(chanRegs),
    .chanMag(chanMag), .chanSource(chanSource), .chanOn(chanOn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] expRegs();
    logic [31:0] v;
    for (int i = 0; i < NCH; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction
  function automatic logic [NCH-1:0] expOn();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = |model[i][6:0];
    return v;
  endfunction
  function automatic logic [NCH-1:0] expSrc();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = (|model[i][6:0]) & model[i][7];
    return v;
  endfunction
  function automatic logic [27:0] expMag();
    logic [27:0] v;
    for (int i = 0; i < NCH; i++) v[i*7 +: 7] = model[i][6:0];
    return v;
  endfunction
  function automatic logic [7:0] expRead(input logic [7:0] p);
    if (p[7:2] == 6'b111110) return model[p[1:0]];
    return 8'h00;
  endfunction

  task automatic checkOutputs(input string req);
    chk({req, " regs"}, chanRegs, expRegs());
    chk("R3 magnitude", {4'b0, chanMag}, {4'b0, expMag()});
    chk("R4 on flags", {28'b0, chanOn}, {28'b0, expOn()});
    chk("R3 R4 source flags", {28'b0, chanSource}, {28'b0, expSrc()});
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(QP);
    sclM = 1'b1; waitQ(QP);
    sdaM = 1'b0; waitQ(QP);
    sclM = 1'b0; waitQ(QP);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(QP);
    sclM = 1'b1; waitQ(QP);
    sdaM = 1'b1; waitQ(2*QP);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(QP);
      sclM = 1'b1; waitQ(2*QP);
      sclM = 1'b0; waitQ(QP);
    end
    sdaM = 1'b1; waitQ(QP);
    sclM = 1'b1; waitQ(QP);
    ack = ~sdaLine;
    waitQ(QP);
    sclM = 1'b0; waitQ(QP);
  endtask

  task automatic readByte(input logic masterAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(QP);
      sclM = 1'b1; waitQ(QP);
      b[i] = sdaLine;
      waitQ(QP);
      sclM = 1'b0;
    end
    waitQ(QP);
    sdaM = ~masterAck; waitQ(QP);
    sclM = 1'b1; waitQ(2*QP);
    sclM = 1'b0; waitQ(QP);
    sdaM = 1'b1;
  endtask

  function automatic logic [7:0] addrByte(input logic [1:0] s, input logic rd);
    return {5'b10010, s, rd};
  endfunction

  task automatic writeReg(input logic [7:0] p, input logic [7:0] d, input string req);
    logic a;
    busStart();
    sendByte(addrByte(strap, 1'b0), a); chk({req, " R1 addr ack"}, {31'b0, a}, 1);
    sendByte(p, a);                     chk({req, " R7 ptr ack"}, {31'b0, a}, 1);
    sendByte(d, a);                     chk({req, " R7 data ack"}, {31'b0, a}, 1);
    busStop();
    ptrModel = p;
    if (p[7:2] == 6'b111110) model[p[1:0]] = d;
  endtask

  task automatic readReg(input logic [7:0] p, input string req);
    logic a;
    logic [7:0] got;
    busStart();
    sendByte(addrByte(strap, 1'b0), a);
    sendByte(p, a);
    ptrModel = p;
    busStart();
    sendByte(addrByte(strap, 1'b1), a); chk({req, " R8 read addr ack"}, {31'b0, a}, 1);
    readByte(1'b0, got);
    chk({req, " R8 read data"}, {24'b0, got}, {24'b0, expRead(p)});
    waitQ(QP);
    chk("R8 released after NACK", {31'b0, sdaDriveLow}, 0);
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] got, got2;
    void'($urandom(32'd1234));
    for (int i = 0; i < NCH; i++) model[i] = 8'h00;
    ptrModel = 8'h00;
    waitQ(5);
    rstN = 1'b1;
    waitQ(3);

    // R5 reset state
    checkOutputs("R5 reset");
    chk("R5 sda released", {31'b0, sdaDriveLow}, 0);

    // R2 R3 source write on channel 1
    writeReg(8'hF9, 8'h85, "R2");
    checkOutputs("R2 R3 ch1 source");

    // R4 zero magnitude with source bit
    writeReg(8'hF8, 8'h80, "R4");
    checkOutputs("R4 zero magnitude");
    writeReg(8'hFB, 8'h3C, "R3");
    checkOutputs("R3 sink ch3");

    // R8 read back
    readReg(8'hF9, "R8 ch1");
    readReg(8'hFB, "R8 ch3");

    // R9 foreign address ignored, R6 repeated start recovers
    busStart();
    sendByte(addrByte(2'b10, 1'b0), a); chk("R9 foreign addr nack", {31'b0, a}, 0);
    sendByte(8'hF8, a);                 chk("R9 ptr not acked", {31'b0, a}, 0);
    sendByte(8'h33, a);                 chk("R9 data not acked", {31'b0, a}, 0);
    checkOutputs("R9 no change");
    busStart();
    sendByte(addrByte(strap, 1'b0), a); chk("R6 repeated start addr ack", {31'b0, a}, 1);
    sendByte(8'hFA, a);
    sendByte(8'h41, a);                 chk("R6 data ack after restart", {31'b0, a}, 1);
    busStop();
    model[2] = 8'h41;
    checkOutputs("R6 write after restart");

    // R10 extra data bytes overwrite the same register
    busStart();
    sendByte(addrByte(strap, 1'b0), a);
    sendByte(8'hFA, a);
    sendByte(8'h11, a);
    sendByte(8'h22, a);
    sendByte(8'hFF, a); chk("R10 third data ack", {31'b0, a}, 1);
    busStop();
    model[2] = 8'hFF;
    checkOutputs("R10 overwrite");

    // R10 read repeats the same register after master ACK
    busStart();
    sendByte(addrByte(strap, 1'b0), a);
    sendByte(8'hF9, a);
    busStart();
    sendByte(addrByte(strap, 1'b1), a);
    readByte(1'b1, got);
    readByte(1'b0, got2);
    busStop();
    chk("R10 read first", {24'b0, got}, {24'b0, model[1]});
    chk("R10 read repeat", {24'b0, got2}, {24'b0, model[1]});

    // R11 out of range pointer
    writeReg(8'h10, 8'h55, "R11");
    checkOutputs("R11 discarded");
    readReg(8'hFC, "R11 out of range");

    // R1 other strap values
    strap = 2'b11;
    busStart();
    sendByte(addrByte(2'b00, 1'b0), a); chk("R1 old address now foreign", {31'b0, a}, 0);
    busStop();
    writeReg(8'hF8, 8'h07, "R1 strap3");
    checkOutputs("R1 strap3");

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [7:0] p, d;
      strap = 2'($urandom_range(0, 3));
      p = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : {6'b111110, 2'($urandom_range(0, 3))};
      d = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 5) == 0) d = {d[7], 7'b0};
      writeReg(p, d, "R7 random");
      checkOutputs("R2 random");
      if (n % 4 == 0) readReg({6'b111110, 2'($urandom_range(0, 3))}, "R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule